// File: doc/BRIEF.md
# Dual-Law Serial Clock Divider

This block derives the serial clock of an SPI controller from its module clock. One packed control word sets the rate. A law-select bit chooses between two division laws. The linear law divides by an even count, 2·(N+1). The exponential law divides by a power of two, 2^(M+1), which reaches the slow rates that the 8-bit linear field cannot. The output is always a square wave with a 50% duty cycle. Its resting level follows the clock-polarity input.

A transfer engine raises `run_i` for as long as it wants clock edges. While `run_i` is low, the counter is cleared, the clock rests at its idle level, and the control word and polarity are copied every cycle. Once running, the divider only takes a new setting when a full period completes, at the edge that returns the clock to idle. This means a rate change can never produce a runt pulse. Two one-cycle strobes mark the leading edge (the clock leaves idle) and the trailing edge (it returns to idle). They are asserted in the same cycle that `sclk_o` shows the new level, so the shift logic can act on them directly.

Top module: `spi_sclk_divider`

## Requirements
- R1: During and right after reset, `sclk_o` is 0, both strobes are 0, and the held setting is exponential with M=0 and polarity 0.
- R2: While `run_i` is low, `sclk_o` equals the polarity sampled one cycle earlier and no strobe is raised; dropping `run_i` mid-period returns `sclk_o` to idle in the next cycle, with no trailing strobe.
- R3: With bit 12 of `ctrl_i` at 1 (linear law), each half period lasts N+1 module cycles, where N is `ctrl_i[7:0]`.
- R4: With bit 12 at 0 (exponential law), each half period lasts 2^M module cycles, where M is `ctrl_i[11:8]`.
- R5: Linear law with N=0 toggles `sclk_o` on every module cycle (divide by 2).
- R6: The exponential law with M=12 gives a full period of 8192 module cycles.
- R7: `lead_o` is high for exactly the one cycle in which `sclk_o` first shows the non-idle level, and `trail_o` for the one cycle in which it first shows idle again; both are never high together.
- R8: The active (non-idle) and idle parts of every period have equal length.
- R9: A change of `ctrl_i` or `cpol_i` while running has no effect until the trailing edge that completes the current period; the next period uses the new setting.
- R10: After `run_i` is first sampled high, the leading edge appears after exactly one half period of the held setting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Module clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ctrl_i | input | 13 | Control word: [7:0] linear N, [11:8] exponent M, [12] law select (1 = linear) |
| cpol_i | input | 1 | Idle level of the serial clock |
| run_i | input | 1 | Clock generation enable from the transfer engine |
| sclk_o | output | 1 | Serial clock |
| lead_o | output | 1 | One-cycle strobe on the leading edge |
| trail_o | output | 1 | One-cycle strobe on the trailing edge |

## Verification
Two functions can land in the same cycle: the trailing edge of a period and the reload of a new setting. The reload is also the point where the half-period counter restarts with a different terminal count. To provoke it, the bench changes `ctrl_i` and `cpol_i` in the middle of an active half period, and also on the cycle just before a trailing edge. A behavioural reference model, compared on every clock, judges the result: the old period must finish with the old length, and the following leading edge must arrive after the new half-period length, with the new idle level. A second collision is `run_i` falling while the clock is in its active half. The model requires an immediate return to idle with no trailing strobe.

// File: rtl/spi_clkdiv_pkg.sv
package spi_clkdiv_pkg;
  parameter int unsigned LIN_W = 8;
  parameter int unsigned EXP_W = 4;
  localparam int unsigned MODE_BIT = LIN_W + EXP_W;
  localparam int unsigned CTRL_W = MODE_BIT + 1;
  localparam int unsigned EXP_SPAN = 1 << EXP_W;
  localparam int unsigned HALF_W = (LIN_W + 1 > EXP_SPAN) ? LIN_W + 1 : EXP_SPAN;

  typedef struct packed {
    logic             lin_mode;
    logic [EXP_W-1:0] exp_m;
    logic [LIN_W-1:0] lin_n;
    logic             cpol;
  } clk_cfg_t;

  // Unpack a control word plus polarity into the held setting.
  function automatic clk_cfg_t unpack_ctrl(input logic [CTRL_W-1:0] w, input logic pol);
    clk_cfg_t c;
    c.lin_n    = w[LIN_W-1:0];
    c.exp_m    = w[MODE_BIT-1:LIN_W];
    c.lin_mode = w[MODE_BIT];
    c.cpol     = pol;
    return c;
  endfunction

  // Module cycles in one half period of the serial clock.
  function automatic logic [HALF_W-1:0] half_len(input clk_cfg_t c);
    logic [HALF_W-1:0] r;
    if (c.lin_mode) r = HALF_W'(c.lin_n) + HALF_W'(1);
    else            r = HALF_W'(1) << c.exp_m;
    return r;
  endfunction
endpackage

// File: rtl/sclk_cfg_hold.sv
module sclk_cfg_hold
  import spi_clkdiv_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [CTRL_W-1:0] ctrl_i,
  input  logic              cpol_i,
  input  logic              load_i,
  output clk_cfg_t          cfg_o
);
  // R9: the setting is only replaced while idle or at a period boundary
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cfg_o <= '0;
    else if (load_i) cfg_o <= unpack_ctrl(ctrl_i, cpol_i);
  end
endmodule

// File: rtl/sclk_half_timer.sv
module sclk_half_timer
  import spi_clkdiv_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              run_i,
  input  logic [HALF_W-1:0] half_i,
  output logic [HALF_W-1:0] cnt_o,
  output logic              tick_o
);
  logic at_end;
  assign at_end = (cnt_o == half_i - HALF_W'(1));
  assign tick_o = run_i && at_end;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_o <= '0;
    else if (!run_i || at_end)  cnt_o <= '0;
    else                        cnt_o <= cnt_o + HALF_W'(1);
  end
endmodule

// File: rtl/sclk_phase_gen.sv
module sclk_phase_gen (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  input  logic tick_i,
  output logic phase_o,
  output logic lead_o,
  output logic trail_o,
  output logic reload_o
);
  // reload happens together with the edge that returns to idle
  assign reload_o = tick_i && phase_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_o <= 1'b0;
      lead_o  <= 1'b0;
      trail_o <= 1'b0;
    end else if (!run_i) begin
      phase_o <= 1'b0;
      lead_o  <= 1'b0;
      trail_o <= 1'b0;
    end else begin
      lead_o  <= tick_i && !phase_o;
      trail_o <= tick_i && phase_o;
      if (tick_i) phase_o <= !phase_o;
    end
  end
endmodule

// File: rtl/spi_sclk_divider.sv
module spi_sclk_divider
  import spi_clkdiv_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [CTRL_W-1:0] ctrl_i,
  input  logic              cpol_i,
  input  logic              run_i,
  output logic              sclk_o,
  output logic              lead_o,
  output logic              trail_o
);
  clk_cfg_t          cfg_q;
  logic [HALF_W-1:0] half_w;
  logic [HALF_W-1:0] cnt_w;
  logic              tick_w;
  logic              phase_w;
  logic              reload_w;
  logic              cfg_load_w;

  assign cfg_load_w = !run_i || reload_w;
  assign half_w     = half_len(cfg_q);

  sclk_cfg_hold u_cfg (
    .clk_i(clk_i), .rst_ni(rst_ni), .ctrl_i(ctrl_i), .cpol_i(cpol_i),
    .load_i(cfg_load_w), .cfg_o(cfg_q)
  );

  sclk_half_timer u_timer (
    .clk_i(clk_i), .rst_ni(rst_ni), .run_i(run_i), .half_i(half_w),
    .cnt_o(cnt_w), .tick_o(tick_w)
  );

  sclk_phase_gen u_phase (
    .clk_i(clk_i), .rst_ni(rst_ni), .run_i(run_i), .tick_i(tick_w),
    .phase_o(phase_w), .lead_o(lead_o), .trail_o(trail_o), .reload_o(reload_w)
  );

  assign sclk_o = phase_w ^ cfg_q.cpol;
endmodule

// File: rtl/spi_sclk_divider_chk.sv
module spi_sclk_divider_chk
  import spi_clkdiv_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              run_i,
  input logic              sclk_o,
  input logic              lead_o,
  input logic              trail_o,
  input clk_cfg_t          cfg_q,
  input logic [HALF_W-1:0] cnt_w,
  input logic              phase_w
);
  p_strobe_excl_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(lead_o && trail_o));

  p_lead_active_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lead_o |-> (sclk_o != cfg_q.cpol));

  p_trail_idle_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trail_o |-> (sclk_o == cfg_q.cpol));

  p_no_strobe_idle_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(run_i) |-> (!lead_o && !trail_o && !phase_w));

  p_cfg_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(cfg_q) |-> (trail_o || !$past(run_i)));

  p_cnt_bound_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_w < half_len(cfg_q));

  p_lead_prev_idle_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lead_o |-> ($past(sclk_o) != sclk_o));
endmodule

bind spi_sclk_divider spi_sclk_divider_chk chk_i (
  .clk_i(clk_i), .rst_ni(rst_ni), .run_i(run_i), .sclk_o(sclk_o),
  .lead_o(lead_o), .trail_o(trail_o), .cfg_q(cfg_q), .cnt_w(cnt_w),
  .phase_w(phase_w)
);

// File: tb/spi_sclk_divider_tb_top.sv
module spi_sclk_divider_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [12:0] ctrl = '0;
  logic        cpol = 1'b0;
  logic        run = 1'b0;
  logic        sclk, lead, trail;

  int n_cmp = 0;
  int n_bad = 0;
  int cyc = 0;
  string cur_req = "R1";

  // reference model state
  bit m_phase, m_lead, m_trail, m_lin, m_cpol;
  int m_cnt, m_n, m_m;

  always #5 clk = ~clk;

  spi_sclk_divider dut_i (
    .clk_i(clk), .rst_ni(rst_n), .ctrl_i(ctrl), .cpol_i(cpol), .run_i(run),
    .sclk_o(sclk), .lead_o(lead), .trail_o(trail)
  );

  function automatic int m_half();
    if (m_lin) return m_n + 1;
    return 1 << m_m;
  endfunction

  task automatic m_load();
    m_n = int'(ctrl[7:0]); m_m = int'(ctrl[11:8]); m_lin = ctrl[12]; m_cpol = cpol;
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_phase = 0; m_lead = 0; m_trail = 0; m_lin = 0; m_cpol = 0; m_cnt = 0;
      m_n = 0; m_m = 0;
    end else if (!run) begin
      m_phase = 0; m_lead = 0; m_trail = 0; m_cnt = 0; m_load();
    end else if (m_cnt == m_half() - 1) begin
      m_cnt = 0; m_lead = !m_phase; m_trail = m_phase;
      if (m_phase) m_load();
      m_phase = !m_phase;
    end else begin
      m_cnt++; m_lead = 0; m_trail = 0;
    end
  end

  task automatic check(string req, string what, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d (t=%0t)", req, what, act, exp, $time);
    end
  endtask

  // per-cycle comparison against the model, away from the active edge
  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      check(cur_req, "sclk", int'(sclk), int'(m_phase ^ m_cpol));
      check("R7", "lead", int'(lead), int'(m_lead));
      check("R7", "trail", int'(trail), int'(m_trail));
    end
  end

  task automatic idle_cycles(int k);
    for (int i = 0; i < k; i++) @(negedge clk);
  endtask

  // run from idle and check first-edge latency, then one period's shape
  task automatic run_and_measure(string req, int half);
    int c;
    run = 1'b1;
    c = 0;
    do begin @(negedge clk); c++; end while (!lead && c < 40000);
    check("R10", "cycles to first lead", c, half);
    c = 0;
    do begin @(negedge clk); c++; end while (!trail && c < 40000);
    check(req, "active half length", c, half);
    c = 0;
    do begin @(negedge clk); c++; end while (!lead && c < 40000);
    check("R8", "idle half length", c, half);
    run = 1'b0;
    idle_cycles(2);
  endtask

  initial begin
    idle_cycles(3);
    check("R1", "sclk in reset", int'(sclk), 0);
    check("R1", "lead in reset", int'(lead), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", "sclk after reset", int'(sclk), 0);
    check("R1", "trail after reset", int'(trail), 0);

    cur_req = "R2"; cpol = 1'b1; idle_cycles(3);
    check("R2", "idle level with cpol 1", int'(sclk), 1);
    cpol = 1'b0; idle_cycles(2);
    check("R2", "idle level with cpol 0", int'(sclk), 0);

    cur_req = "R3"; ctrl = {1'b1, 4'd9, 8'd3}; idle_cycles(1);
    run_and_measure("R3", 4);
    ctrl = {1'b1, 4'd0, 8'd10}; idle_cycles(1);
    run_and_measure("R3", 11);

    cur_req = "R5"; ctrl = {1'b1, 4'd5, 8'd0}; idle_cycles(1);
    run_and_measure("R5", 1);

    cur_req = "R4"; ctrl = {1'b0, 4'd2, 8'd7}; idle_cycles(1);
    run_and_measure("R4", 4);
    ctrl = {1'b0, 4'd0, 8'd200}; idle_cycles(1);
    run_and_measure("R4", 1);

    cur_req = "R6"; ctrl = {1'b0, 4'd12, 8'd0}; idle_cycles(1);
    run_and_measure("R6", 4096);

    cur_req = "R8"; cpol = 1'b1; ctrl = {1'b1, 4'd0, 8'd5}; idle_cycles(1);
    run_and_measure("R8", 6);
    cpol = 1'b0;

    // R9: change setting mid-period; model judges when it takes effect
    cur_req = "R9"; ctrl = {1'b1, 4'd0, 8'd2}; idle_cycles(1);
    run = 1'b1;
    idle_cycles(4);
    ctrl = {1'b1, 4'd0, 8'd6}; cpol = 1'b1;
    idle_cycles(40);
    // change on the cycle just before a trailing edge
    while (!(sclk == 1'b0 && !trail)) @(negedge clk);
    while (!trail) @(negedge clk);
    idle_cycles(12);
    ctrl = {1'b0, 4'd1, 8'd0}; cpol = 1'b0;
    idle_cycles(40);

    // R2: drop run during the active half, no trailing strobe
    cur_req = "R2";
    while (!lead) @(negedge clk);
    run = 1'b0;
    @(negedge clk);
    check("R2", "sclk after run drop", int'(sclk), 0);
    check("R2", "no trail on run drop", int'(trail), 0);
    idle_cycles(5);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    wait (cyc > 150000);
    n_bad++;
    n_cmp++;
    $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule